// File: doc/BRIEF.md
# Per-State Sticky Fault Recorder

This block keeps one sticky fault bit for each monitored supply input. A fault pulse on an input sets that input's bit, and the bit stays set until software clears it. The sequencer state in force supplies a latch enable. While the current state has the latch turned off, new fault pulses are not recorded, and bits captured earlier are kept. This lets a design keep the faults seen in one state while the expected undervoltage during a ramp-up or ramp-down is not recorded.

Beside the sticky bits, the block reports live condition flags that are not latched. These are an undervoltage flag and an overvoltage flag for each input, and a set of converter limit flags. A reader can tell a recorded event apart from a condition that is present now.

Reads use a valid/ready request channel and a valid/ready response channel. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high whenever the response slot is empty, or is being emptied in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response word is held unchanged and no new request is accepted. Clears use a plain strobe with a word select and a bit mask.

Top module: `flt_latch_top`

## Requirements
- R1: After reset, every sticky fault bit is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: On a clock edge where `latch_en` is 1, each input whose `fault_in` bit is 1 gets its sticky bit set. The bit then stays set on later cycles until it is cleared.
- R3: On a clock edge where `latch_en` is 0, no sticky bit goes from 0 to 1. Bits that are already set stay set unless they are cleared.
- R4: When `clr_stb` is 1, sticky bits are cleared, one for each 1 in `clr_mask`. If `clr_sel` is 0, bit k of the mask clears input k. If `clr_sel` is 1, bit k of the mask clears input 8+k. Bits that are not selected are unchanged.
- R5: If a bit is cleared on the same edge that latches a new fault for it, the bit stays 1. A clear with no enabled fault on that edge takes effect.
- R6: Read address 0 returns the sticky bits of inputs 0–7 in bits 0–7. Address 1 returns inputs 8–15 in bits 0–7. A bit position with no input behind it reads 0.
- R7: Addresses 2 and 3 return the live undervoltage flags, and addresses 4 and 5 return the live overvoltage flags. Each pair uses the same low-word/high-word split as R6. These flags are not latched: a read shows the input value at the acceptance edge.
- R8: Address 6 returns the live converter limit flags in its low bits, with the unused bits set to 0. Address 7 returns 0.
- R9: A read request is accepted on an edge where `req_valid` and `req_ready` are both 1. The response appears with `rsp_valid` = 1 after that edge. `req_ready` is 0 while `rsp_valid` is 1 and `rsp_ready` is 0. During that time `rsp_data` does not change.
- R10: A response word holds the sticky and live values from just before its acceptance edge. A fault latched on that same edge shows up only in later reads. The latch enable is sampled on the same edge as the fault inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_en | input | 1 | Recording enable from the current sequencer state |
| fault_in | input | NUM_IN | Per-input fault pulses |
| uv_in | input | NUM_IN | Live undervoltage flags |
| ov_in | input | NUM_IN | Live overvoltage flags |
| adc_lim_in | input | NUM_ADC | Live converter limit flags |
| clr_stb | input | 1 | Clear strobe |
| clr_sel | input | 1 | Fault word the clear applies to |
| clr_mask | input | 8 | Write-one-to-clear bit mask |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request ready |
| req_addr | input | 3 | Read register address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response word |

## Verification
The bench builds the block with NUM_IN = 12 and NUM_ADC = 6. With those values the high fault, undervoltage and overvoltage words each have four bit positions with no input behind them, and the converter word has two, so the reads-as-zero rule can be checked at the ports. Twelve inputs also put real bits in both words. That lets the bench confirm that a clear of one word leaves the other word alone. Response back-pressure is held for several cycles while faults and live flags change, and this exposes any leak into a held response.

// File: rtl/flt_latch_pkg.sv
package flt_latch_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 3;
  localparam int PAIR_W = 2 * WORD_W;

  typedef enum logic [ADDR_W-1:0] {
    RA_FLT_LO = 3'd0,
    RA_FLT_HI = 3'd1,
    RA_UV_LO  = 3'd2,
    RA_UV_HI  = 3'd3,
    RA_OV_LO  = 3'd4,
    RA_OV_HI  = 3'd5,
    RA_ADC    = 3'd6,
    RA_RSVD   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/flt_clr_decode.sv
module flt_clr_decode
  import flt_latch_pkg::*;
#(
  parameter int NUM_IN = 12
) (
  input  logic              clr_stb,
  input  logic              clr_sel,
  input  logic [WORD_W-1:0] clr_mask,
  output logic [NUM_IN-1:0] clr_vec
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    localparam logic WSEL = (i >= WORD_W);
    localparam int   BPOS = i % WORD_W;
    assign clr_vec[i] = clr_stb && (clr_sel == WSEL) && clr_mask[BPOS];
  end
endmodule

// File: rtl/flt_sticky_bank.sv
module flt_sticky_bank #(
  parameter int NUM_IN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [NUM_IN-1:0] fault_in,
  input  logic [NUM_IN-1:0] clr_vec,
  output logic [NUM_IN-1:0] flt_q
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_cell
    logic set_now;
    assign set_now = latch_en && fault_in[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          flt_q[i] <= 1'b0;
      else if (set_now)    flt_q[i] <= 1'b1;
      else if (clr_vec[i]) flt_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flt_read_mux.sv
module flt_read_mux
  import flt_latch_pkg::*;
#(
  parameter int NUM_IN  = 12,
  parameter int NUM_ADC = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_IN-1:0]  flt,
  input  logic [NUM_IN-1:0]  uv,
  input  logic [NUM_IN-1:0]  ov,
  input  logic [NUM_ADC-1:0] adc,
  output logic [WORD_W-1:0]  word
);
  logic [PAIR_W-1:0] flt_p, uv_p, ov_p;
  logic [WORD_W-1:0] adc_p;

  always_comb begin
    flt_p = '0;
    uv_p  = '0;
    ov_p  = '0;
    adc_p = '0;
    flt_p[NUM_IN-1:0] = flt;
    uv_p[NUM_IN-1:0]  = uv;
    ov_p[NUM_IN-1:0]  = ov;
    adc_p[NUM_ADC-1:0] = adc;
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      RA_FLT_LO: word = flt_p[WORD_W-1:0];
      RA_FLT_HI: word = flt_p[PAIR_W-1:WORD_W];
      RA_UV_LO:  word = uv_p[WORD_W-1:0];
      RA_UV_HI:  word = uv_p[PAIR_W-1:WORD_W];
      RA_OV_LO:  word = ov_p[WORD_W-1:0];
      RA_OV_HI:  word = ov_p[PAIR_W-1:WORD_W];
      RA_ADC:    word = adc_p;
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/flt_rsp_stage.sv
module flt_rsp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] din,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  logic take;
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        rsp_data  <= din;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flt_latch_top.sv
module flt_latch_top
  import flt_latch_pkg::*;
#(
  parameter int NUM_IN  = 12,
  parameter int NUM_ADC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_en,
  input  logic [NUM_IN-1:0]  fault_in,
  input  logic [NUM_IN-1:0]  uv_in,
  input  logic [NUM_IN-1:0]  ov_in,
  input  logic [NUM_ADC-1:0] adc_lim_in,
  input  logic               clr_stb,
  input  logic               clr_sel,
  input  logic [7:0]         clr_mask,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_data
);
  logic [NUM_IN-1:0] clr_vec;
  logic [NUM_IN-1:0] flt_q;
  logic [WORD_W-1:0] rd_word;

  flt_clr_decode #(.NUM_IN(NUM_IN)) u_clr (
    .clr_stb (clr_stb),
    .clr_sel (clr_sel),
    .clr_mask(clr_mask),
    .clr_vec (clr_vec)
  );

  flt_sticky_bank #(.NUM_IN(NUM_IN)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_en(latch_en),
    .fault_in(fault_in),
    .clr_vec (clr_vec),
    .flt_q   (flt_q)
  );

  flt_read_mux #(.NUM_IN(NUM_IN), .NUM_ADC(NUM_ADC)) u_mux (
    .addr(req_addr),
    .flt (flt_q),
    .uv  (uv_in),
    .ov  (ov_in),
    .adc (adc_lim_in),
    .word(rd_word)
  );

  flt_rsp_stage #(.W(WORD_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .din      (rd_word),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data)
  );
endmodule

// File: rtl/flt_latch_chk.sv
module flt_latch_chk #(
  parameter int NUM_IN = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_en,
  input logic [NUM_IN-1:0] fault_in,
  input logic              clr_stb,
  input logic [NUM_IN-1:0] flt_q,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data
);
  AST_SET_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en && (|fault_in) |=> ((flt_q & $past(fault_in)) == $past(fault_in))); // R2

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> ((flt_q & ~$past(flt_q)) == '0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en && !clr_stb |=> $stable(flt_q)); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en && clr_stb |=> ((flt_q & $past(fault_in)) == $past(fault_in))); // R5

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9

  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
endmodule

bind flt_latch_top flt_latch_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .latch_en (latch_en),
  .fault_in (fault_in),
  .clr_stb  (clr_stb),
  .flt_q    (flt_q),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data)
);

// File: tb/flt_latch_top_bench.sv
module flt_latch_top_bench;
  localparam int NI = 12;
  localparam int NA = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          latch_en = 1'b0;
  logic [NI-1:0] fault_in = '0;
  logic [NI-1:0] uv_in = '0;
  logic [NI-1:0] ov_in = '0;
  logic [NA-1:0] adc_lim_in = '0;
  logic          clr_stb = 1'b0;
  logic          clr_sel = 1'b0;
  logic [7:0]    clr_mask = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_data;

  int total = 0;
  int bad = 0;
  logic [NI-1:0] exp_flt = '0;

  always #10 clk = ~clk;

  flt_latch_top #(.NUM_IN(NI), .NUM_ADC(NA)) u_flt_latch_top (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .fault_in(fault_in),
    .uv_in(uv_in), .ov_in(ov_in), .adc_lim_in(adc_lim_in),
    .clr_stb(clr_stb), .clr_sel(clr_sel), .clr_mask(clr_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flt_word(input logic sel);
    logic [15:0] p;
    p = '0;
    p[NI-1:0] = exp_flt;
    return sel ? p[15:8] : p[7:0];
  endfunction

  // one clock of stimulus, then inputs return to idle; model updated per R2-R5
  task automatic step(input logic [NI-1:0] f, input logic en,
                      input logic cs, input logic sel, input logic [7:0] m);
    logic [NI-1:0] cv;
    @(negedge clk);
    fault_in = f; latch_en = en; clr_stb = cs; clr_sel = sel; clr_mask = m;
    cv = '0;
    for (int i = 0; i < NI; i++)
      cv[i] = cs && (sel == (i >= 8)) && m[i % 8];
    exp_flt = (exp_flt & ~cv) | (en ? f : '0);
    @(negedge clk);
    fault_in = '0; clr_stb = 1'b0; clr_mask = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    total++;
    if (rsp_valid !== 1'b1) begin
      bad++;
      $display("FAIL R9: rsp_valid actual=%b expected=1", rsp_valid);
    end
    d = rsp_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    chk("R1 req_ready", {7'd0, req_ready}, 8'h01);
    rd(3'd0, d); chk("R1 lo", d, 8'h00);
    rd(3'd1, d); chk("R1 hi", d, 8'h00);
  endtask

  task automatic t_set_enabled();
    logic [7:0] d;
    step(12'h005, 1'b1, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R2 sticky lo", d, flt_word(1'b0));
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    step(12'h8A0, 1'b0, 1'b0, 1'b0, 8'h00);
    rd(3'd0, d); chk("R3 lo kept", d, flt_word(1'b0));
    rd(3'd1, d); chk("R3 hi unset", d, flt_word(1'b1));
  endtask

  task automatic t_layout();
    logic [7:0] d;
    step(12'hC00, 1'b1, 1'b0, 1'b0, 8'h00);
    rd(3'd1, d); chk("R6 hi word", d, 8'h0C);
    rd(3'd0, d); chk("R6 lo word", d, 8'h05);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    step('0, 1'b0, 1'b1, 1'b0, 8'h01);
    rd(3'd0, d); chk("R4 lo after clear", d, 8'h04);
    rd(3'd1, d); chk("R4 hi untouched", d, 8'h0C);
    step('0, 1'b0, 1'b1, 1'b1, 8'hFF);
    rd(3'd1, d); chk("R4 hi cleared", d, 8'h00);
    rd(3'd0, d); chk("R4 lo untouched", d, 8'h04);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    step(12'h004, 1'b1, 1'b1, 1'b0, 8'h04);
    rd(3'd0, d); chk("R5 set beats clear", d, 8'h04);
    step(12'h004, 1'b0, 1'b1, 1'b0, 8'h04);
    rd(3'd0, d); chk("R5 clear with disabled fault", d, 8'h00);
  endtask

  task automatic t_boundary();
    logic [7:0] d;
    @(negedge clk);
    latch_en = 1'b1; fault_in = 12'h001;
    @(negedge clk);
    latch_en = 1'b0; fault_in = 12'h002;
    @(negedge clk);
    fault_in = '0;
    exp_flt |= 12'h001;
    rd(3'd0, d); chk("R10 state boundary", d, 8'h01);
    // read accepted on the same edge that latches a fault
    @(negedge clk);
    latch_en = 1'b1; fault_in = 12'h008; req_valid = 1'b1; req_addr = 3'd0;
    @(negedge clk);
    req_valid = 1'b0; fault_in = '0; latch_en = 1'b0;
    chk("R10 same-edge read", rsp_data, 8'h01);
    exp_flt |= 12'h008;
    rd(3'd0, d); chk("R10 later read", d, 8'h09);
  endtask

  task automatic t_live();
    logic [7:0] d;
    @(negedge clk); uv_in = 12'hA5F; ov_in = 12'h3C1;
    rd(3'd2, d); chk("R7 uv lo", d, 8'h5F);
    rd(3'd3, d); chk("R7 uv hi", d, 8'h0A);
    rd(3'd4, d); chk("R7 ov lo", d, 8'hC1);
    rd(3'd5, d); chk("R7 ov hi", d, 8'h03);
    @(negedge clk); uv_in = '0;
    rd(3'd2, d); chk("R7 uv follows input", d, 8'h00);
    rd(3'd0, d); chk("R7 sticky unaffected", d, 8'h09);
  endtask

  task automatic t_adc();
    logic [7:0] d;
    @(negedge clk); adc_lim_in = 6'h2B;
    rd(3'd6, d); chk("R8 adc", d, 8'h2B);
    @(negedge clk); adc_lim_in = 6'h3F;
    rd(3'd6, d); chk("R8 adc unused zero", d, 8'h3F);
    rd(3'd7, d); chk("R8 reserved", d, 8'h00);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 3'd0;
    @(negedge clk);
    req_addr = 3'd6;
    chk("R9 first accepted", rsp_data, 8'h09);
    chk("R9 ready low", {7'd0, req_ready}, 8'h00);
    latch_en = 1'b1; fault_in = 12'h0F0; adc_lim_in = 6'h01;
    @(negedge clk);
    fault_in = '0; latch_en = 1'b0;
    exp_flt |= 12'h0F0;
    repeat (2) @(negedge clk);
    chk("R9 held data", rsp_data, 8'h09);
    chk("R9 held valid", {7'd0, rsp_valid}, 8'h01);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next after release", rsp_data, 8'h01);
    @(negedge clk);
    chk("R9 drained", {7'd0, rsp_valid}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_enabled();
    t_disabled();
    t_layout();
    t_clear();
    t_set_wins();
    t_boundary();
    t_live();
    t_adc();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule